// File: doc/BRIEF.md
# Block-Framed Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus (clock and open-drain data). It holds seven 8-bit control bytes whose fields drive the enable, stop-response and select logic of a multi-output clock generator. It also returns live pin values and power-on strap values for software to read back. The serial lines are asynchronous to the system clock. Both lines pass through synchronisers and are oversampled, so all protocol state runs on `clk_i`.

Transfers always start at the first control byte and use block framing. A write carries the slave address and two filler bytes. The control bytes then follow, lowest index first. A read first returns a length byte and then the control bytes in the same order. A STOP may end either transfer at any point. The block does not stretch the clock, does not arbitrate and does not accept a repeated START in the middle of a transfer.

Top module: `clkctl_serial_regs`

## Requirements
- R1: After a matching address with the direction bit (LSB of the address byte) at 0, the slave pulls data low in the ninth clock of the address byte and of every following byte. The first two data bytes are discarded. The next seven bytes load control bytes 0 to 6 in that order.
- R2: The slave acknowledges only its own 7-bit address (parameter, default 7'h69). For any other address it leaves data released in the ninth clock and ignores all traffic until the next START. No control byte changes.
- R3: After a matching address with the direction bit at 1, the slave sends the value 8 first, then control bytes 0 to 6, each MSB first. A master NACK ends the sending.
- R4: Writable bits per byte are 0:{7,5,3}, 1:{5..0}, 2:{6..0}, 3:{7..0}, 4:{5..0}, 5:{3..0}, and none in byte 6. Writes to any other bit are ignored. Unused bits (byte0 bit6, byte1 bit6, byte2 bit7, byte4 bits 7:6, byte5 bits 7:4) read 0.
- R5: The reset values are byte0 bit3 = 1, byte1 bits 2:0 = 1, byte2 bits 6:0 = 1, byte3 bits 2:0 and 7:6 = 1, byte4 bits 5:0 = 1, and every other writable bit 0.
- R6: Byte 0 reads back as follows: bits 2:0 hold the latched `freq_strap_i` (bit n = strap n); bit 3 is the stored bit ANDed with `bus_stop_ni`; bit 4 is the live value of `host_stop_ni`.
- R7: Byte 1 bit 7 reads the latched `drive_strap_i`. Both straps are captured on the first clock after reset release, and later changes on those pins are ignored.
- R8: Byte 6 always reads 8'h07 (ID 4'b0111 in bits 3:0, revision 0 in bits 7:4), and writes to it have no effect.
- R9: A STOP at any point returns the slave to idle with data released. Every byte whose eighth bit was received before the STOP stays written, and later bytes keep their old values.
- R10: Data is sampled on the rising clock edge. The slave changes its data drive only while the synchronised clock is low.
- R11: Output fields map from the stored bits: spread_en_o = b0[7], alt48_sel_o = b0[5], bus_stop_reg_o = b0[3], host_en_o = b1[2:0], host_stop_resp_o = b1[5:3], bus33_en_o = b2[6:0], free33_en_o = b3[2:0], free33_stop_mask_o = b3[5:3], fix48_en_o = b3[7:6], mid66_en_o = b4[5:0], edge_ctl_o = b5[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| freq_strap_i | input | 3 | Frequency strap pins, latched after reset |
| drive_strap_i | input | 1 | Drive-current strap pin, latched after reset |
| host_stop_ni | input | 1 | Live host-clock stop pin, active low |
| bus_stop_ni | input | 1 | Live bus-clock stop pin, active low |
| spread_en_o | output | 1 | Spread modulation enable |
| alt48_sel_o | output | 1 | Shared output runs at 48 MHz when 1 |
| bus_stop_reg_o | output | 1 | Stored bus-stop control bit |
| host_en_o | output | 3 | Host clock pair enables |
| host_stop_resp_o | output | 3 | Host pairs that obey the stop pin |
| bus33_en_o | output | 7 | Stoppable 33 MHz output enables |
| free33_en_o | output | 3 | Free-running 33 MHz output enables |
| free33_stop_mask_o | output | 3 | Free-running outputs that obey the stop pin |
| fix48_en_o | output | 2 | Fixed 48 MHz output enables |
| mid66_en_o | output | 6 | 66 MHz output enables |
| edge_ctl_o | output | 4 | Edge-rate controls |

## Verification
The hardest case to reach is a STOP that cuts a block write short. The two filler bytes must already have gone through, some control bytes must be committed and the rest untouched. The bench writes a known pattern, then sends the address, both fillers and two bytes of all ones, and issues STOP. A full block read then shows bytes 0 and 1 changed and byte 2 still holding the old value. The AND of the stored bus-stop bit with its pin is also hard to see, since the stored bit is hidden behind the pin. The bench sets the stored bit first and then pulls the pin low and high around readbacks.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int NUM_BYTES   = 7;
  localparam int DUMMY_BYTES = 2;
  localparam int SEL_W       = $clog2(NUM_BYTES + 1);
  localparam int IDX_W       = $clog2(NUM_BYTES + DUMMY_BYTES + 2);
  localparam logic [7:0] BLOCK_COUNT = 8'(NUM_BYTES + 1);
  localparam logic [7:0] ID_BYTE     = 8'h07;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SACK, ST_WRX, ST_TX, ST_MACK
  } eng_state_e;

  function automatic logic [7:0] wmask(int i);
    case (i)
      0:       return 8'b1010_1000;
      1:       return 8'b0011_1111;
      2:       return 8'b0111_1111;
      3:       return 8'b1111_1111;
      4:       return 8'b0011_1111;
      5:       return 8'b0000_1111;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(int i);
    case (i)
      0:       return 8'b0000_1000;
      1:       return 8'b0000_0111;
      2:       return 8'b0111_1111;
      3:       return 8'b1100_0111;
      4:       return 8'b0011_1111;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkctl_line_sync.sv
module clkctl_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q    <= '1;
        prev_o[l] <= 1'b1;
      end else begin
        pipe_q    <= {pipe_q[STAGES-2:0], raw_i[l]};
        prev_o[l] <= pipe_q[STAGES-1];
      end
    end
    assign lvl_o[l] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/clkctl_frame_engine.sv
module clkctl_frame_engine
  import clkctl_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             scl_p_i,
  input  logic             sda_s_i,
  input  logic             sda_p_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [SEL_W-1:0] wr_sel_o,
  output logic [7:0]       wr_data_o,
  output logic [SEL_W-1:0] rd_sel_o,
  input  logic [7:0]       rd_data_i
);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;
  localparam logic [IDX_W-1:0] WR_FIRST = IDX_W'(DUMMY_BYTES);
  localparam logic [IDX_W-1:0] WR_END   = IDX_W'(DUMMY_BYTES + NUM_BYTES);
  localparam logic [IDX_W-1:0] RD_END   = IDX_W'(NUM_BYTES);

  eng_state_e       state_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       sh_q, tx_sh_q, tx_byte;
  logic [IDX_W-1:0] idx_q;
  logic             rnw_q;

  wire scl_rise = scl_s_i & ~scl_p_i;
  wire scl_fall = ~scl_s_i & scl_p_i;
  wire start_det = scl_s_i & scl_p_i & sda_p_i & ~sda_s_i;
  wire stop_det  = scl_s_i & scl_p_i & ~sda_p_i & sda_s_i;
  wire byte_done = scl_fall && bit_cnt_q == 4'd8;

  assign wr_en_o   = state_q == ST_WRX && byte_done && idx_q >= WR_FIRST && idx_q < WR_END;
  assign wr_sel_o  = SEL_W'(idx_q - WR_FIRST);
  assign wr_data_o = sh_q;
  assign rd_sel_o  = SEL_W'(idx_q - 1'b1);
  assign tx_byte   = (idx_q == '0) ? BLOCK_COUNT : (idx_q <= RD_END) ? rd_data_i : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_sh_q   <= '0;
      idx_q     <= '0;
      rnw_q     <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      sda_oe_o  <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WRX: begin
          if (scl_rise) begin
            sh_q      <= {sh_q[6:0], sda_s_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            if (state_q == ST_WRX) begin
              sda_oe_o <= 1'b1;
              state_q  <= ST_SACK;
              if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
            end else if (sh_q[7:1] == SLAVE_ADDR) begin
              sda_oe_o <= 1'b1;
              rnw_q    <= sh_q[0];
              state_q  <= ST_SACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_SACK: if (scl_fall) begin
          bit_cnt_q <= '0;
          if (rnw_q) begin
            tx_sh_q  <= tx_byte;
            sda_oe_o <= ~tx_byte[7];
            state_q  <= ST_TX;
          end else begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_WRX;
          end
        end
        ST_TX: begin
          if (scl_rise) bit_cnt_q <= bit_cnt_q + 4'd1;
          else if (byte_done) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_MACK;
          end else if (scl_fall) begin
            tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
            sda_oe_o <= ~tx_sh_q[6];
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_s_i) state_q <= ST_IDLE;
            else if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
          end else if (scl_fall) begin
            bit_cnt_q <= '0;
            tx_sh_q   <= tx_byte;
            sda_oe_o  <= ~tx_byte[7];
            state_q   <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s_i);
  a_r2_no_ack_foreign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && byte_done && sh_q[7:1] != SLAVE_ADDR) |=> (!sda_oe_o && state_q == ST_IDLE));
  a_r9_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE && !sda_oe_o));
  a_r3_count_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SACK && scl_fall && rnw_q && idx_q == '0) |=> tx_sh_q == BLOCK_COUNT);
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
  import clkctl_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [SEL_W-1:0]              wr_sel_i,
  input  logic [7:0]                    wr_data_i,
  input  logic [SEL_W-1:0]              rd_sel_i,
  output logic [7:0]                    rd_data_o,
  input  logic [2:0]                    freq_strap_i,
  input  logic                          drive_strap_i,
  input  logic                          host_stop_ni,
  input  logic                          bus_stop_ni,
  output logic [NUM_BYTES-1:0][7:0]     regs_o
);
  logic [NUM_BYTES-1:0][7:0] regs_q;
  logic [2:0] strap_q;
  logic       drive_q, strap_done_q;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    localparam logic [7:0] WM = wmask(g);
    localparam logic [7:0] RV = rst_val(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= RV;
      else if (wr_en_i && wr_sel_i == SEL_W'(g))
        regs_q[g] <= (regs_q[g] & ~WM) | (wr_data_i & WM);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q      <= '0;
      drive_q      <= 1'b0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      strap_q      <= freq_strap_i;
      drive_q      <= drive_strap_i;
      strap_done_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (int'(rd_sel_i) < NUM_BYTES) rd_data_o = regs_q[rd_sel_i] & wmask(int'(rd_sel_i));
    case (int'(rd_sel_i))
      0: begin
        rd_data_o[2:0] = strap_q;
        rd_data_o[3]   = rd_data_o[3] & bus_stop_ni;
        rd_data_o[4]   = host_stop_ni;
      end
      1: rd_data_o[7] = drive_q;
      NUM_BYTES - 1: rd_data_o = ID_BYTE;
      default: ;
    endcase
  end

  assign regs_o = regs_q;

  a_r4_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q));
  a_r7_strap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done_q |=> ($stable(strap_q) && $stable(drive_q)));
endmodule

// File: rtl/clkctl_serial_regs.sv
module clkctl_serial_regs
  import clkctl_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] freq_strap_i,
  input  logic       drive_strap_i,
  input  logic       host_stop_ni,
  input  logic       bus_stop_ni,
  output logic       spread_en_o,
  output logic       alt48_sel_o,
  output logic       bus_stop_reg_o,
  output logic [2:0] host_en_o,
  output logic [2:0] host_stop_resp_o,
  output logic [6:0] bus33_en_o,
  output logic [2:0] free33_en_o,
  output logic [2:0] free33_stop_mask_o,
  output logic [1:0] fix48_en_o,
  output logic [5:0] mid66_en_o,
  output logic [3:0] edge_ctl_o
);
  logic [1:0] lvl, prev;
  logic             wr_en;
  logic [SEL_W-1:0] wr_sel, rd_sel;
  logic [7:0]       wr_data, rd_data;
  logic [NUM_BYTES-1:0][7:0] regs;

  clkctl_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i, .rst_ni, .raw_i({sda_i, scl_i}), .lvl_o(lvl), .prev_o(prev)
  );

  clkctl_frame_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_engine (
    .clk_i, .rst_ni,
    .scl_s_i(lvl[0]), .scl_p_i(prev[0]), .sda_s_i(lvl[1]), .sda_p_i(prev[1]),
    .sda_oe_o, .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
    .rd_sel_o(rd_sel), .rd_data_i(rd_data)
  );

  clkctl_regfile u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .freq_strap_i, .drive_strap_i, .host_stop_ni, .bus_stop_ni, .regs_o(regs)
  );

  assign spread_en_o        = regs[0][7];
  assign alt48_sel_o        = regs[0][5];
  assign bus_stop_reg_o     = regs[0][3];
  assign host_en_o          = regs[1][2:0];
  assign host_stop_resp_o   = regs[1][5:3];
  assign bus33_en_o         = regs[2][6:0];
  assign free33_en_o        = regs[3][2:0];
  assign free33_stop_mask_o = regs[3][5:3];
  assign fix48_en_o         = regs[3][7:6];
  assign mid66_en_o         = regs[4][5:0];
  assign edge_ctl_o         = regs[5][3:0];

  logic unused_bits;
  assign unused_bits = ^{regs[0][6], regs[0][4:0], regs[1][7:6], regs[2][7],
                         regs[4][7:6], regs[5][7:4], regs[6]};
endmodule

// File: tb/clkctl_serial_regs_tb_top.sv
module clkctl_serial_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [2:0] freq_strap = 3'b101;
  logic drive_strap = 1'b1, host_stop_n = 1'b1, bus_stop_n = 1'b1;
  logic spread_en, alt48_sel, bus_stop_reg;
  logic [2:0] host_en, host_stop_resp, free33_en, free33_stop_mask;
  logic [6:0] bus33_en;
  logic [1:0] fix48_en;
  logic [5:0] mid66_en;
  logic [3:0] edge_ctl;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] wbuf [7];
  logic [7:0] rbuf [7];
  logic [7:0] rcount;

  always #10 clk = ~clk;

  clkctl_serial_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .freq_strap_i(freq_strap), .drive_strap_i(drive_strap),
    .host_stop_ni(host_stop_n), .bus_stop_ni(bus_stop_n),
    .spread_en_o(spread_en), .alt48_sel_o(alt48_sel), .bus_stop_reg_o(bus_stop_reg),
    .host_en_o(host_en), .host_stop_resp_o(host_stop_resp), .bus33_en_o(bus33_en),
    .free33_en_o(free33_en), .free33_stop_mask_o(free33_stop_mask),
    .fix48_en_o(fix48_en), .mid66_en_o(mid66_en), .edge_ctl_o(edge_ctl)
  );

  // {write bytes 0..6, expected readback 0..6}, straps 101/1, pins high
  localparam logic [111:0] VEC [4] = '{
    {56'hFF_FF_FF_FF_FF_FF_FF, 56'hBD_BF_7F_FF_3F_0F_07},
    {56'h00_00_00_00_00_00_00, 56'h15_80_00_00_00_00_07},
    {56'hA5_5A_3C_C3_96_69_FF, 56'hB5_9A_3C_C3_16_09_07},
    {56'h08_07_55_38_21_0A_00, 56'h1D_87_55_38_21_0A_07}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nak);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); nak = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
    end
    q(); sda_m = ~ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  // address, two fillers, n bytes of wbuf, STOP
  task automatic wr_block(input logic [6:0] addr, input int n, output logic addr_nak, output int data_naks);
    logic nk;
    data_naks = 0;
    bus_start();
    send_byte({addr, 1'b0}, addr_nak);
    send_byte(8'h00, nk); data_naks += int'(nk);
    send_byte(8'h00, nk); data_naks += int'(nk);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], nk); data_naks += int'(nk);
    end
    bus_stop();
  endtask

  task automatic rd_block(output logic addr_nak);
    bus_start();
    send_byte({7'h69, 1'b1}, addr_nak);
    recv_byte(1'b1, rcount);
    for (int i = 0; i < 7; i++) recv_byte(i != 6, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic nak;
    int dn;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    freq_strap = 3'b010; drive_strap = 1'b0;  // R7: late strap changes ignored

    // R5 reset values at the outputs
    chk("R5 host_en", 64'(host_en), 64'h7);
    chk("R5 bus33_en", 64'(bus33_en), 64'h7F);
    chk("R5 mid66_en", 64'(mid66_en), 64'h3F);
    chk("R5 fix48/free33", 64'({fix48_en, free33_en, free33_stop_mask}), 64'b11_111_000);
    chk("R5 misc zero", 64'({spread_en, alt48_sel, host_stop_resp, edge_ctl}), 64'h0);
    chk("R5 bus_stop_reg", 64'(bus_stop_reg), 64'h1);
    chk("R10 idle release", 64'(sda_oe), 64'h0);

    // R3 count and reset readback; R6/R7 strap values latched at reset
    rd_block(nak);
    chk("R3 addr ack", 64'(nak), 64'h0);
    chk("R3 count", 64'(rcount), 64'h8);
    chk("R6 R7 byte0 reset", 64'(rbuf[0]), 64'h1D);
    chk("R7 byte1 reset", 64'(rbuf[1]), 64'h87);
    chk("R5 byte3 reset", 64'(rbuf[3]), 64'hC7);
    chk("R8 id", 64'(rbuf[6]), 64'h07);

    // table: R1 R4 R8 write masks and readback
    foreach (VEC[v]) begin
      for (int i = 0; i < 7; i++) wbuf[i] = VEC[v][111 - 8*i -: 8];
      wr_block(7'h69, 7, nak, dn);
      chk("R1 addr ack", 64'(nak), 64'h0);
      chk("R1 data acks", 64'(dn), 64'h0);
      rd_block(nak);
      chk("R3 count", 64'(rcount), 64'h8);
      for (int i = 0; i < 7; i++)
        chk($sformatf("R4 row%0d byte%0d", v, i), 64'(rbuf[i]), 64'(VEC[v][55 - 8*i -: 8]));
      if (v == 2) begin
        chk("R11 host", 64'({host_en, host_stop_resp}), 64'b010_011);
        chk("R11 bus33", 64'(bus33_en), 64'h3C);
        chk("R11 free33/fix48", 64'({fix48_en, free33_stop_mask, free33_en}), 64'b11_000_011);
        chk("R11 mid66/edge", 64'({mid66_en, edge_ctl}), 64'({6'h16, 4'h9}));
        chk("R11 byte0 bits", 64'({spread_en, alt48_sel, bus_stop_reg}), 64'b110);
      end
    end

    // R2 foreign address: no ack, nothing written
    for (int i = 0; i < 7; i++) wbuf[i] = 8'h00;
    wr_block(7'h68, 7, nak, dn);
    chk("R2 no addr ack", 64'(nak), 64'h1);
    chk("R2 no data ack", 64'(dn), 64'h9);
    rd_block(nak);
    chk("R2 byte0 kept", 64'(rbuf[0]), 64'h1D);
    chk("R2 byte2 kept", 64'(rbuf[2]), 64'h55);

    // R9 STOP after two data bytes
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    wr_block(7'h69, 2, nak, dn);
    chk("R9 slave idle", 64'(sda_oe), 64'h0);
    rd_block(nak);
    chk("R9 byte0 committed", 64'(rbuf[0]), 64'hBD);
    chk("R9 byte1 committed", 64'(rbuf[1]), 64'hBF);
    chk("R9 byte2 untouched", 64'(rbuf[2]), 64'h55);

    // R6 AND with bus stop pin, live host stop pin
    bus_stop_n = 1'b0;
    rd_block(nak);
    chk("R6 and pin low", 64'(rbuf[0]), 64'hB5);
    chk("R6 stored bit kept", 64'(bus_stop_reg), 64'h1);
    host_stop_n = 1'b0;
    rd_block(nak);
    chk("R6 live host pin", 64'(rbuf[0]), 64'hA5);
    bus_stop_n = 1'b1; host_stop_n = 1'b1;
    rd_block(nak);
    chk("R6 pins restored", 64'(rbuf[0]), 64'hBD);

    // R3 early NACK after count, then a full read still works
    bus_start();
    send_byte({7'h69, 1'b1}, nak);
    recv_byte(1'b0, rcount);
    bus_stop();
    chk("R3 short read count", 64'(rcount), 64'h8);
    chk("R10 released after nack", 64'(sda_oe), 64'h0);
    rd_block(nak);
    chk("R3 read after nack", 64'(rbuf[1]), 64'hBF);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule